// File: doc/BRIEF.md
# Memory Burst Splitter with Access-Port Register Caching

This block sits between a debug host's memory-transfer logic and a serial scan engine. It takes one request (start address, number of 32-bit data-register accesses, access size, direction, and target port number) and produces the stream of register-access commands that carries the transfer out through an access port. Before the data accesses, it may emit a bank-select write, a control-word write and a transfer-address write. Each of these writes is sent only when its value differs from the value the block believes the hardware already holds.

Data accesses go out in bursts that use address auto-increment. A burst never runs past the auto-increment wrap boundary, whose size in bytes is a parameter. After each burst, the block issues a status read and waits for the scan engine to report the result. A failed burst is issued again, once per transfer. A second failure ends the transfer with an error flag.

A transfer of exactly one word uses a different path. It runs without auto-increment and goes through the banked data registers, which lets repeated accesses within one 16-byte line reuse a cached transfer address.

Top module: `ap_burst_splitter`

## Requirements
- R1: The words available in a burst before the wrap boundary equal (BOUNDARY − ((BOUNDARY−1) & addr)) >> 2. BOUNDARY must be a power of two of at least 1024 bytes. No auto-increment burst runs past the boundary.
- R2: The burst length is the smaller of the remaining word count and the words available before the boundary. When that minimum is 0, because the address is unaligned within the last word before the boundary, the burst has one word.
- R3: The transfer-address write (kind 2, register 0x04) is issued only when its target differs from the cached transfer address. The target is the current address in burst mode, or the address with bits 3:0 cleared in single-word mode.
- R4: The control word is CTRL_FIXED OR (increment mode << 4) OR size. The increment mode is 0 = off for single-word transfers, 1 = single when size is 2 (word), and 2 = packed otherwise. The control word is written (kind 2, register 0x00) only when it differs from the cached value. Every burst that uses auto-increment invalidates the cached transfer address.
- R5: The bank-select write (kind 0, register 0x08) carries the port number in bits 31:24 and the bank in bits 7:4, with every other bit zero. It is issued only when the needed bank differs from the cached bank. Bank 0 is needed before the control and address writes. The data phase needs bank 1 for single-word transfers and bank 0 otherwise.
- R6: A request whose port differs from the previous request's port invalidates the cached bank, control word and transfer address. The first command of that transfer is therefore a bank-select write.
- R7: A single-word transfer accesses register 0x10 | (addr & 0xC) in the data phase.
- R8: Each burst ends with a status read (kind 1, register 0x04). The block then waits for chk_valid. On a failure the same burst is repeated, once per transfer. A further failure raises done together with done_err.
- R9: The command order within a burst is: bank 0 select, control word, transfer address, data-phase bank select, data accesses, status read. Any of the first four is skipped when it is not needed. A command held without cmd_ready keeps its kind, register and data.
- R10: A burst-mode data access uses register 0x0C, with kind 2 for writes and kind 3 for reads. Its data field carries the word index within the transfer, counted from 0.
- R11: A request with a word count of 0 emits no command and raises done, without done_err, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears all caches |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 32 | Start byte address |
| req_words | input | CNT_W | Number of data-register accesses |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | PORT_W | Target access-port number |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Scan engine accepts the command |
| cmd_kind | output | 2 | 0 port write, 1 port read, 2 access-port write, 3 access-port read |
| cmd_addr | output | 8 | Register address |
| cmd_data | output | 32 | Write value, or word index for data accesses |
| chk_valid | input | 1 | Status result for the last burst |
| chk_ok | input | 1 | Status result is clean |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| done_err | output | 1 | Transfer aborted after a repeated failure (valid with done) |

## Verification
The hardest state to reach from the ports is a cache that is stale in exactly one register: the bank cached from a single-word transfer, a transfer address invalidated by an earlier burst, or a control word left by a different size. The stimulus chains requests on purpose to build these states. A burst-mode read is followed by single-word reads in the same 16-byte line, then by a port change, then by retries. As a result, every skip and every rewrite decision depends on the history left by the previous transfer. A burst with a length of zero is reached through a multi-word request starting two bytes below a boundary. Failure paths are driven by choosing the status answers burst by burst.

// File: rtl/ap_burst_pkg.sv
package ap_burst_pkg;
   typedef enum logic [1:0] {
      K_PORT_WR = 2'd0,
      K_PORT_RD = 2'd1,
      K_AP_WR   = 2'd2,
      K_AP_RD   = 2'd3
   } cmd_kind_e;

   typedef enum logic [3:0] {
      S_IDLE, S_BANK0, S_CTRL, S_TADDR, S_BANKD, S_DATA, S_STAT, S_WAIT, S_DONE
   } split_state_e;

   localparam logic [7:0] RA_BANKSEL = 8'h08;
   localparam logic [7:0] RA_STATUS  = 8'h04;
   localparam logic [7:0] RA_CTRL    = 8'h00;
   localparam logic [7:0] RA_TADDR   = 8'h04;
   localparam logic [7:0] RA_DATA    = 8'h0C;
   localparam logic [7:0] RA_BANKED  = 8'h10;

   localparam logic [1:0] INC_OFF    = 2'd0;
   localparam logic [1:0] INC_SINGLE = 2'd1;
   localparam logic [1:0] INC_PACKED = 2'd2;
endpackage

// File: rtl/ap_burst_window.sv
module ap_burst_window #(
   parameter int BOUNDARY = 1024,
   parameter int CNT_W    = 16,
   localparam int OFS_W   = $clog2(BOUNDARY)
) (
   input  logic [OFS_W-1:0] addr_lo,
   input  logic [CNT_W-1:0] remaining,
   output logic [CNT_W-1:0] burst_len
);
   localparam int AV_W = OFS_W + 1;
   localparam int CW   = (CNT_W > AV_W) ? CNT_W : AV_W;

   if (BOUNDARY < 1024 || (BOUNDARY & (BOUNDARY - 1)) != 0) begin : g_bad_boundary
      $error("ap_burst_window: BOUNDARY must be a power of two >= 1024");
   end

   logic [AV_W-1:0] span;
   logic [AV_W-1:0] avail;
   logic [CW-1:0]   av_x, rem_x, pick;

   always_comb begin
      span  = AV_W'(BOUNDARY) - {1'b0, addr_lo};
      avail = span >> 2;
      av_x  = CW'(avail);
      rem_x = CW'(remaining);
      pick  = (rem_x < av_x) ? rem_x : av_x;
      burst_len = (pick == '0) ? CNT_W'(1) : CNT_W'(pick);
   end
endmodule

// File: rtl/ap_reg_cache.sv
module ap_reg_cache #(
   parameter int DATA_W   = 32,
   parameter bit CACHE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_all,
   input  logic              inv_taddr,
   input  logic [3:0]        bank_in,
   input  logic              upd_bank,
   input  logic [DATA_W-1:0] ctrl_in,
   input  logic              upd_ctrl,
   input  logic [DATA_W-1:0] taddr_in,
   input  logic              upd_taddr,
   output logic              bank_hit,
   output logic              ctrl_hit,
   output logic              taddr_hit
);
   if (CACHE_EN) begin : g_cached
      logic              bank_v, ctrl_v, taddr_v;
      logic [3:0]        bank_q;
      logic [DATA_W-1:0] ctrl_q, taddr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_v  <= 1'b0;
            ctrl_v  <= 1'b0;
            taddr_v <= 1'b0;
            bank_q  <= '0;
            ctrl_q  <= '0;
            taddr_q <= '0;
         end else if (inv_all) begin
            bank_v  <= 1'b0;
            ctrl_v  <= 1'b0;
            taddr_v <= 1'b0;
         end else begin
            if (upd_bank) begin
               bank_v <= 1'b1;
               bank_q <= bank_in;
            end
            if (upd_ctrl) begin
               ctrl_v <= 1'b1;
               ctrl_q <= ctrl_in;
            end
            if (inv_taddr) begin
               taddr_v <= 1'b0;
            end else if (upd_taddr) begin
               taddr_v <= 1'b1;
               taddr_q <= taddr_in;
            end
         end
      end

      assign bank_hit  = bank_v  && (bank_q  == bank_in);
      assign ctrl_hit  = ctrl_v  && (ctrl_q  == ctrl_in);
      assign taddr_hit = taddr_v && (taddr_q == taddr_in);
   end else begin : g_uncached
      assign bank_hit  = 1'b0;
      assign ctrl_hit  = 1'b0;
      assign taddr_hit = 1'b0;
   end
endmodule

// File: rtl/ap_burst_splitter.sv
module ap_burst_splitter
   import ap_burst_pkg::*;
#(
   parameter int          BOUNDARY   = 1024,
   parameter int          CNT_W      = 16,
   parameter int          PORT_W     = 8,
   parameter bit          CACHE_EN   = 1'b1,
   parameter logic [31:0] CTRL_FIXED = 32'h0300_0080
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_addr,
   input  logic [CNT_W-1:0]  req_words,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [PORT_W-1:0] req_port,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_kind,
   output logic [7:0]        cmd_addr,
   output logic [31:0]       cmd_data,
   input  logic              chk_valid,
   input  logic              chk_ok,
   output logic              done,
   output logic              done_err
);
   localparam int OFS_W = $clog2(BOUNDARY);

   if (PORT_W > 8 || PORT_W < 1) begin : g_bad_port
      $error("ap_burst_splitter: PORT_W must be 1..8");
   end
   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt
      $error("ap_burst_splitter: CNT_W must be 2..30");
   end

   split_state_e      st;
   logic [31:0]       addr_q;
   logic [CNT_W-1:0]  rem_q, idx_q, beat_q;
   logic [1:0]        size_q;
   logic              wr_q, single_q, retried_q, err_q;
   logic [PORT_W-1:0] port_q;

   logic [CNT_W-1:0]  blen;
   logic [1:0]        inc_mode;
   logic [31:0]       ctrl_val, taddr_tgt, bank_word;
   logic [3:0]        bank_need;
   logic              bank_hit, ctrl_hit, taddr_hit;
   logic              hs, accept, port_chg, last_beat;
   logic              inv_taddr, upd_bank, upd_ctrl, upd_taddr;

   ap_burst_window #(.BOUNDARY(BOUNDARY), .CNT_W(CNT_W)) u_window (
      .addr_lo   (addr_q[OFS_W-1:0]),
      .remaining (rem_q),
      .burst_len (blen)
   );

   ap_reg_cache #(.DATA_W(32), .CACHE_EN(CACHE_EN)) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .inv_all   (accept && port_chg),
      .inv_taddr (inv_taddr),
      .bank_in   (bank_need),
      .upd_bank  (upd_bank),
      .ctrl_in   (ctrl_val),
      .upd_ctrl  (upd_ctrl),
      .taddr_in  (taddr_tgt),
      .upd_taddr (upd_taddr),
      .bank_hit  (bank_hit),
      .ctrl_hit  (ctrl_hit),
      .taddr_hit (taddr_hit)
   );

   always_comb begin
      inc_mode  = single_q ? INC_OFF : ((size_q == 2'd2) ? INC_SINGLE : INC_PACKED);
      ctrl_val  = CTRL_FIXED | (32'(inc_mode) << 4) | 32'(size_q);
      taddr_tgt = single_q ? {addr_q[31:4], 4'b0000} : addr_q;
      bank_need = (st == S_BANKD && single_q) ? 4'd1 : 4'd0;
      bank_word = (32'(port_q) << 24) | (32'(bank_need) << 4);
      last_beat = (beat_q == blen - CNT_W'(1));
   end

   always_comb begin
      cmd_valid = 1'b0;
      cmd_kind  = K_PORT_WR;
      cmd_addr  = RA_BANKSEL;
      cmd_data  = bank_word;
      unique case (st)
         S_BANK0, S_BANKD: cmd_valid = !bank_hit;
         S_CTRL: begin
            cmd_valid = !ctrl_hit;
            cmd_kind  = K_AP_WR;
            cmd_addr  = RA_CTRL;
            cmd_data  = ctrl_val;
         end
         S_TADDR: begin
            cmd_valid = !taddr_hit;
            cmd_kind  = K_AP_WR;
            cmd_addr  = RA_TADDR;
            cmd_data  = taddr_tgt;
         end
         S_DATA: begin
            cmd_valid = 1'b1;
            cmd_kind  = wr_q ? K_AP_WR : K_AP_RD;
            cmd_addr  = single_q ? (RA_BANKED | {4'b0, addr_q[3:2], 2'b00}) : RA_DATA;
            cmd_data  = 32'(idx_q + beat_q);
         end
         S_STAT: begin
            cmd_valid = 1'b1;
            cmd_kind  = K_PORT_RD;
            cmd_addr  = RA_STATUS;
            cmd_data  = '0;
         end
         default: cmd_valid = 1'b0;
      endcase
   end

   assign hs        = cmd_valid && cmd_ready;
   assign req_ready = (st == S_IDLE);
   assign accept    = req_ready && req_valid;
   assign port_chg  = (req_port != port_q);
   assign upd_bank  = (st == S_BANK0 || st == S_BANKD) && hs;
   assign upd_ctrl  = (st == S_CTRL) && hs;
   assign upd_taddr = (st == S_TADDR) && hs;
   assign inv_taddr = (st == S_TADDR) && (taddr_hit || hs) && (inc_mode != INC_OFF);
   assign done      = (st == S_DONE);
   assign done_err  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         addr_q    <= '0;
         rem_q     <= '0;
         idx_q     <= '0;
         beat_q    <= '0;
         size_q    <= '0;
         wr_q      <= 1'b0;
         single_q  <= 1'b0;
         retried_q <= 1'b0;
         err_q     <= 1'b0;
         port_q    <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               err_q <= 1'b0;
               if (req_valid) begin
                  addr_q    <= req_addr;
                  rem_q     <= req_words;
                  idx_q     <= '0;
                  size_q    <= req_size;
                  wr_q      <= req_write;
                  single_q  <= (req_words == CNT_W'(1));
                  retried_q <= 1'b0;
                  port_q    <= req_port;
                  st        <= (req_words == '0) ? S_DONE : S_BANK0;
               end
            end
            S_BANK0: if (bank_hit || hs) st <= S_CTRL;
            S_CTRL:  if (ctrl_hit || hs) st <= S_TADDR;
            S_TADDR: if (taddr_hit || hs) st <= S_BANKD;
            S_BANKD: if (bank_hit || hs) begin
               st     <= S_DATA;
               beat_q <= '0;
            end
            S_DATA: if (hs) begin
               if (last_beat) st <= S_STAT;
               else beat_q <= beat_q + CNT_W'(1);
            end
            S_STAT: if (hs) st <= S_WAIT;
            S_WAIT: if (chk_valid) begin
               if (chk_ok) begin
                  if (rem_q == blen) begin
                     st <= S_DONE;
                  end else begin
                     addr_q <= addr_q + (32'(blen) << 2);
                     rem_q  <= rem_q - blen;
                     idx_q  <= idx_q + blen;
                     st     <= S_BANK0;
                  end
               end else if (retried_q) begin
                  err_q <= 1'b1;
                  st    <= S_DONE;
               end else begin
                  retried_q <= 1'b1;
                  st        <= S_BANK0;
               end
            end
            S_DONE: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // R9: a stalled command is held unchanged
   assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_data));

   // R1: an auto-increment burst stays inside the wrap window
   assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DATA && !single_q) |->
         (blen == CNT_W'(1)) ||
         ((32'(addr_q[OFS_W-1:0]) + (32'(blen) << 2)) <= 32'(BOUNDARY)));

   // R2: burst length is non-zero and never exceeds the remaining words
   assert_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DATA) |-> (blen != '0) && (blen <= rem_q));

   // R5: bank-select word format
   assert_bank_fmt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && cmd_kind == K_PORT_WR && cmd_addr == RA_BANKSEL) |->
         (cmd_data[31:24] == 8'(port_q)) && ((cmd_data & 32'h00FF_FF0F) == 32'h0));

   // R6: after a port change the first command is a bank-select write
   assert_port_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && port_chg && req_words != '0) |=>
         cmd_valid && cmd_kind == K_PORT_WR && cmd_addr == RA_BANKSEL);

   // R8: an error completion implies a retry already took place
   assert_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> retried_q);
endmodule

// File: tb/tb_ap_burst_splitter.sv
`timescale 1ns/1ps
module tb_ap_burst_splitter;
   localparam int          B      = 1024;
   localparam int          CNT_W  = 16;
   localparam logic [31:0] FIXED  = 32'h0300_0080;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [31:0]       req_addr = '0;
   logic [CNT_W-1:0]  req_words = '0;
   logic [1:0]        req_size = 2'd2;
   logic              req_write = 1'b0;
   logic [7:0]        req_port = '0;
   logic              cmd_valid;
   logic              cmd_ready = 1'b1;
   logic [1:0]        cmd_kind;
   logic [7:0]        cmd_addr;
   logic [31:0]       cmd_data;
   logic              chk_valid = 1'b0;
   logic              chk_ok = 1'b0;
   logic              done, done_err;

   ap_burst_splitter dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_words(req_words), .req_size(req_size), .req_write(req_write),
      .req_port(req_port),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .chk_valid(chk_valid), .chk_ok(chk_ok),
      .done(done), .done_err(done_err)
   );

   always #2 clk = ~clk;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit stall = 1'b0;
   bit stat_seen = 1'b0;

   int          qk[$];
   int          qa[$];
   logic [31:0] qd[$];

   // reference cache state
   bit          m_bank_v, m_ctrl_v, m_taddr_v, m_port_v;
   int          m_bank;
   logic [31:0] m_ctrl, m_taddr;
   logic [7:0]  m_port;

   function automatic string tag_of(int k, int a);
      if (k == 0) return "R5";
      if (k == 1) return "R8";
      if (k == 2 && a == 0) return "R4";
      if (k == 2 && a == 4) return "R3";
      if (a >= 16) return "R7";
      return "R10";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   // scan engine model and cycle-by-cycle comparison against the reference queue (R9)
   always @(negedge clk) begin
      cyc++;
      cmd_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (rst_n && cmd_valid && cmd_ready) begin
         if (qk.size() == 0) begin
            check(1'b0, "R9", "unexpected command", {cmd_kind, 6'b0, cmd_addr, 16'b0}, 32'h0);
         end else begin
            int k, a; logic [31:0] d;
            k = qk.pop_front(); a = qa.pop_front(); d = qd.pop_front();
            tests++;
            if (32'(cmd_kind) != 32'(k) || 32'(cmd_addr) != 32'(a) || cmd_data != d) begin
               fails++;
               $display("FAIL %s cmd: actual k=%0d a=%h d=%h expected k=%0d a=%h d=%h",
                        tag_of(k, a), cmd_kind, cmd_addr, cmd_data, k, a[7:0], d);
            end
            if (k == 1) stat_seen = 1'b1;
         end
      end
   end

   task automatic push(input int k, input int a, input logic [31:0] d);
      qk.push_back(k); qa.push_back(a); qd.push_back(d);
   endtask

   task automatic push_burst(input logic [31:0] cur, input int len, input int idx,
                             input bit single, input logic [31:0] ctrl, input bit inc_on,
                             input bit wr, input logic [7:0] port);
      logic [31:0] tgt;
      int bank;
      if (!m_bank_v || m_bank != 0) begin
         push(0, 8, {port, 24'h0}); m_bank_v = 1; m_bank = 0;
      end
      if (!m_ctrl_v || m_ctrl != ctrl) begin
         push(2, 0, ctrl); m_ctrl_v = 1; m_ctrl = ctrl;
      end
      tgt = single ? {cur[31:4], 4'h0} : cur;
      if (!m_taddr_v || m_taddr != tgt) begin
         push(2, 4, tgt); m_taddr_v = 1; m_taddr = tgt;
      end
      if (inc_on) m_taddr_v = 0;
      bank = single ? 1 : 0;
      if (!m_bank_v || m_bank != bank) begin
         push(0, 8, {port, 16'h0, 4'(bank), 4'h0}); m_bank_v = 1; m_bank = bank;
      end
      for (int j = 0; j < len; j++)
         push(wr ? 2 : 3, single ? (16 | int'(cur & 32'hC)) : 12, 32'(idx + j));
      push(1, 4, 32'h0);
   endtask

   task automatic xfer(input logic [31:0] a, input int n, input logic [1:0] sz,
                       input bit wr, input logic [7:0] port, input int failmask,
                       input bit exp_err);
      int rem, len, avail, idx, sti;
      bit retried, single, inc_on, fin, ok;
      logic [31:0] cur, ctrl;
      if (!m_port_v || m_port != port) begin // R6
         m_bank_v = 0; m_ctrl_v = 0; m_taddr_v = 0;
      end
      m_port_v = 1; m_port = port;
      single = (n == 1);
      inc_on = !single;
      ctrl = FIXED | (32'(single ? 0 : (sz == 2'd2 ? 1 : 2)) << 4) | 32'(sz);
      req_addr = a; req_words = CNT_W'(n); req_size = sz; req_write = wr; req_port = port;
      if (n == 0) begin
         req_valid = 1'b1;
         @(negedge clk); req_valid = 1'b0;
         check(done === 1'b1 && done_err === 1'b0, "R11", "zero-count done", {30'b0, done, done_err}, 32'h2);
         @(negedge clk);
         check(qk.size() == 0, "R11", "no command", qk.size(), 0);
         return;
      end
      rem = n; cur = a; idx = 0; retried = 0; sti = 0; fin = 0;
      while (!fin) begin
         avail = (B - ((B - 1) & int'(cur))) >> 2;   // R1
         len = (rem < avail) ? rem : avail;          // R2
         if (len == 0) len = 1;
         push_burst(cur, len, idx, single, ctrl, inc_on, wr, port);
         if (sti == 0) begin
            req_valid = 1'b1;
            @(negedge clk); req_valid = 1'b0;
         end
         while (!stat_seen) @(negedge clk);
         stat_seen = 1'b0;
         @(negedge clk);
         check(qk.size() == 0, "R9", "commands outstanding at status", qk.size(), 0);
         ok = !failmask[sti];
         sti++;
         if (ok) begin
            if (rem == len) fin = 1;
            else begin rem -= len; cur += 32'(len) << 2; idx += len; end
         end else if (retried) fin = 1;
         else retried = 1;
         chk_ok = ok; chk_valid = 1'b1;
         @(negedge clk); chk_valid = 1'b0;
         if (fin)
            check(done === 1'b1 && done_err === exp_err, "R8", "completion",
                  {30'b0, done, done_err}, {30'b0, 1'b1, exp_err});
         else
            check(done === 1'b0, "R8", "no early done", {31'b0, done}, 32'h0);
      end
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0, "R9", "reset state",
            {29'b0, req_ready, cmd_valid, done}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 burst write, cold caches
      xfer(32'h0000_1000, 8, 2'd2, 1'b1, 8'h00, 0, 1'b0);
      // R1 R2 read that meets a boundary after two words; second burst rewrites address
      xfer(32'h0000_13F8, 6, 2'd2, 1'b0, 8'h00, 0, 1'b0);
      // R7 single-word read: control word change, line address, banked register
      xfer(32'h0000_2034, 1, 2'd2, 1'b0, 8'h00, 0, 1'b0);
      // R3 same line: address write skipped, bank reselected
      xfer(32'h0000_2038, 1, 2'd2, 1'b0, 8'h00, 0, 1'b0);
      // R6 port switch invalidates all caches
      xfer(32'h0000_203C, 1, 2'd2, 1'b1, 8'h03, 0, 1'b0);
      // R8 one failure, retried burst succeeds
      xfer(32'h0000_0100, 4, 2'd2, 1'b1, 8'h03, 1, 1'b0);
      // R8 two failures abort with error
      xfer(32'h0000_0200, 3, 2'd2, 1'b0, 8'h03, 3, 1'b1);
      // R2 unaligned start two bytes below a boundary gives a one-word burst
      xfer(32'h0000_03FE, 2, 2'd2, 1'b0, 8'h03, 0, 1'b0);
      // R4 packed halfword transfer under stalling ready
      stall = 1'b1;
      xfer(32'h0000_0800, 3, 2'd1, 1'b1, 8'h03, 0, 1'b0);
      // R11 zero count
      xfer(32'h0000_0000, 0, 2'd2, 1'b0, 8'h03, 0, 1'b0);
      // R1 long read spanning two boundaries: bursts 256, 256, 88
      xfer(32'h0000_0000, 600, 2'd2, 1'b0, 8'h03, 0, 1'b0);
      stall = 1'b0;
      // R4 same request again with the same control word: only the address is rewritten
      xfer(32'h0000_0040, 2, 2'd2, 1'b0, 8'h03, 0, 1'b0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule